// File: doc/BRIEF.md
# Serial Configuration Port with Staged Commit

This block is the control port for a bank of eight 32-bit configuration registers. A host drives a serial clock, a data line and a load strobe. The block samples all three in its own system clock domain. Each serial clock rising edge shifts one data bit into a 32-bit word, most significant bit first. When the load strobe rises, the word is written to the register named by its three low bits.

Some fields are staged rather than applied at once. A write to register 1 or register 2 places those fields in a pending copy. Every pending field then reaches the active outputs together on the next write to register 0. This lets a 25-bit fractional value split across registers 1 and 0 change in one step. It also lets divider, doubler, halver and current settings change in that same step. A rising edge on a separate request line loads a 37-bit status word, which is then shifted out serially on the data-out pin.

Top module: `scp_top`

## Requirements
- R1: After reset, all register outputs, `frac_o`, `commit_o`, `frame_err_o` and `sdo_o` are 0. No register changes before the first rising edge of `sle_i`.
- R2: Each synchronized rising edge of `sclk_i` shifts `sdata_i` into a 32-bit word, MSB first. A rising edge of `sle_i` writes the last 32 bits shifted in.
- R3: Word bits [2:0] select the destination register 0..7. The whole word, including those bits, is stored there, and no other register changes apart from the staged commit of R6.
- R4: Bits that are not staged take effect on the write itself. This covers all bits of registers 3..7, bits outside [15:3] of register 1, and bits outside [25:15] of register 2.
- R5: Staged bits (register 1 bits [15:3], register 2 bits [25:15]) go to a pending copy. The active value is unchanged until a register 0 write.
- R6: A register 0 write updates register 0 and copies every pending field to the active registers in the same cycle. The last pending write to a register wins.
- R7: `commit_o` is a one-cycle pulse, asserted in the cycle that register 0 takes its new value. It fires on every register 0 write, even with nothing pending.
- R8: `frac_o` equals {active reg0[14:3], active reg1[15:3]}.
- R9: At each load, `frame_err_o` becomes 1 if the number of shift edges since the previous load was not exactly 32, and 0 otherwise. The last 32 bits are still written. It changes only at a load.
- R10: A rising edge of `txdata_i` loads `status_i`. `sdo_o` then shows bit 36 and advances one bit on each falling `sclk_i` edge. After 37 falling edges it returns to 0, and it is 0 whenever no readback is in progress.
- R11: During a readback, `sclk_i` edges neither shift the write word nor count toward the frame length. The `txdata_i` rising edge clears the edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Serial write data |
| sle_i | input | 1 | Load strobe; rising edge writes the word |
| txdata_i | input | 1 | Readback request; rising edge loads status |
| status_i | input | 37 | Status word for readback |
| sdo_o | output | 1 | Serial readback data |
| regs_o | output | 256 | Active registers, register k at bits [32k+31:32k] |
| frac_o | output | 25 | Active 25-bit fractional value |
| commit_o | output | 1 | One-cycle pulse on staged commit |
| frame_err_o | output | 1 | Last load saw other than 32 shift edges |

## Verification
The checker assumes that `sle_i` and `txdata_i` rise at least a few system clocks apart. It also assumes that no `sclk_i` edge and no strobe edge reach the synchronizer in the same cycle, and that every serial level holds for more than three system clocks. The stimulus keeps each serial phase at six or more system clocks, with data set three clocks before the clock edge. It also leaves idle gaps between the load pulse, the readback request and the next shift.

// File: rtl/scp_pkg.sv
package scp_pkg;
  parameter int unsigned WORD_W   = 32;
  parameter int unsigned NUM_REGS = 8;
  parameter int unsigned RB_W     = 37;
  parameter int unsigned SYNC_N   = 2;
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS);
  localparam int unsigned FRAC_W  = 25;

  // staged (double-buffered) bits per register
  function automatic logic [WORD_W-1:0] stage_mask(int unsigned idx);
    case (idx)
      1:       return WORD_W'(32'h0000_FFF8);
      2:       return WORD_W'(32'h03FF_8000);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  input  logic              load_i,
  input  logic              hold_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_ok_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take;

  assign take = sclk_rise_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (take) sh_q <= {sh_q[WORD_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i || clr_i)          cnt_q <= '0;
    else if (take && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign word_o     = sh_q;
  assign frame_ok_o = (cnt_q == CNT_W'(WORD_W));
endmodule

// File: rtl/scp_bank.sv
module scp_bank
  import scp_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned W      = WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [W-1:0]             word_i,
  input  logic                     frame_ok_i,
  output logic [N_REGS-1:0][W-1:0] act_o,
  output logic                     commit_o,
  output logic                     frame_err_o
);
  localparam int unsigned AW = $clog2(N_REGS);

  logic [AW-1:0] addr;
  logic          base_wr;

  assign addr    = word_i[AW-1:0];
  assign base_wr = wr_i && (addr == '0);

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    localparam logic [W-1:0] MASK = stage_mask(g);
    logic [W-1:0] act_q, pend_q;
    logic         sel;

    assign sel = wr_i && (addr == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= '0;
        pend_q <= '0;
      end else if (sel) begin
        pend_q <= word_i & MASK;
        act_q  <= (act_q & MASK) | (word_i & ~MASK);
      end else if (base_wr) begin
        act_q  <= (act_q & ~MASK) | pend_q;
      end
    end

    assign act_o[g] = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o    <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      commit_o <= base_wr;
      if (wr_i) frame_err_o <= !frame_ok_i;
    end
  end
endmodule

// File: rtl/scp_readback.sv
module scp_readback #(
  parameter int unsigned RB_W = 37
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [RB_W-1:0] data_i,
  input  logic            shift_i,
  output logic            busy_o,
  output logic            sdo_o
);
  localparam int unsigned CW = $clog2(RB_W + 1);

  logic [RB_W-1:0] sh_q;
  logic [CW-1:0]   left_q;
  logic            busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= CW'(RB_W);
      busy_q <= 1'b1;
    end else if (shift_i && busy_q) begin
      sh_q   <= {sh_q[RB_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign sdo_o  = busy_q & sh_q[RB_W-1];
endmodule

// File: rtl/scp_top.sv
module scp_top
  import scp_pkg::*;
#(
  parameter int unsigned N_REGS = NUM_REGS,
  parameter int unsigned W      = WORD_W,
  parameter int unsigned RBW    = RB_W,
  parameter int unsigned STAGES = SYNC_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                sdata_i,
  input  logic                sle_i,
  input  logic                txdata_i,
  input  logic [RBW-1:0]      status_i,
  output logic                sdo_o,
  output logic [N_REGS*W-1:0] regs_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                commit_o,
  output logic                frame_err_o
);
  // bit order: {txdata, le, data, sclk}
  logic [3:0] lvl, rise, fall;
  logic [W-1:0] word;
  logic frame_ok, rb_busy;
  logic [N_REGS-1:0][W-1:0] act;

  scp_sync #(.WIDTH(4), .STAGES(STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({txdata_i, sle_i, sdata_i, sclk_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  scp_shifter #(.WORD_W(W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (rise[0]),
    .sdata_i     (lvl[1]),
    .load_i      (rise[2]),
    .hold_i      (rb_busy),
    .clr_i       (rise[3]),
    .word_o      (word),
    .frame_ok_o  (frame_ok)
  );

  scp_bank #(.N_REGS(N_REGS), .W(W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (rise[2]),
    .word_i      (word),
    .frame_ok_i  (frame_ok),
    .act_o       (act),
    .commit_o    (commit_o),
    .frame_err_o (frame_err_o)
  );

  scp_readback #(.RB_W(RBW)) u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rise[3]),
    .data_i  (status_i),
    .shift_i (fall[0]),
    .busy_o  (rb_busy),
    .sdo_o   (sdo_o)
  );

  for (genvar g = 0; g < N_REGS; g++) begin : g_out
    assign regs_o[g*W +: W] = act[g];
  end

  assign frac_o = {act[0][14:3], act[1][15:3]};
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
  parameter int unsigned TOT_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [2:0]       wr_addr_i,
  input logic             commit_o,
  input logic             frame_err_o,
  input logic             rb_busy_i,
  input logic             sdo_o,
  input logic [TOT_W-1:0] regs_o
);
  // R7
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R7
  commit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_i && wr_addr_i == 3'd0));

  // R5
  staged_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o[47:35]) |-> commit_o);

  // R3
  reg_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_o) |-> $past(wr_i));

  // R9
  frame_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_err_o) |-> $past(wr_i));

  // R10
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_busy_i |-> !sdo_o);
endmodule

bind scp_top scp_chk #(.TOT_W(N_REGS*W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (rise[2]),
  .wr_addr_i   (word[2:0]),
  .commit_o    (commit_o),
  .frame_err_o (frame_err_o),
  .rb_busy_i   (rb_busy),
  .sdo_o       (sdo_o),
  .regs_o      (regs_o)
);

// File: tb/scp_top_tb.sv
module scp_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0, txd = 1'b0;
  logic [36:0] status = '0;
  logic sdo, commit, ferr;
  logic [255:0] regs;
  logic [24:0] frac;

  int total = 0, bad = 0;
  int commits_seen = 0, commits_exp = 0;
  logic [31:0] reg0_at_commit = '0;

  logic [31:0] exp_act [8];
  logic [31:0] exp_pend [8];
  logic [31:0] sh_m = '0;
  int cnt_m = 0;
  logic exp_err = 1'b0;

  always #2 clk = ~clk;

  scp_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdat), .sle_i(sle),
    .txdata_i(txd), .status_i(status), .sdo_o(sdo), .regs_o(regs),
    .frac_o(frac), .commit_o(commit), .frame_err_o(ferr)
  );

  always @(negedge clk) if (rst_n && commit) begin
    commits_seen++;
    reg0_at_commit = regs[31:0];
  end

  function automatic logic [31:0] mask_of(int k);
    if (k == 1) return 32'h0000_FFF8;
    if (k == 2) return 32'h03FF_8000;
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdat = b; cyc(3);
    sclk = 1'b1; cyc(6);
    sclk = 1'b0; cyc(6);
    sh_m = {sh_m[30:0], b};
    cnt_m++;
  endtask

  task automatic load_pulse();
    logic [31:0] w;
    int a;
    w = sh_m; a = int'(w[2:0]);
    sle = 1'b1; cyc(6);
    sle = 1'b0; cyc(8);
    exp_err = (cnt_m != 32);
    cnt_m = 0;
    if (a == 0) begin
      exp_act[0] = w;
      for (int k = 1; k < 8; k++)
        exp_act[k] = (exp_act[k] & ~mask_of(k)) | exp_pend[k];
      commits_exp++;
    end else begin
      exp_pend[a] = w & mask_of(a);
      exp_act[a] = (exp_act[a] & mask_of(a)) | (w & ~mask_of(a));
    end
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    load_pulse();
  endtask

  task automatic write_word(input logic [31:0] w);
    send_bits({32'h0, w}, 32);
  endtask

  task automatic check_regs(input string tag);
    for (int k = 0; k < 8; k++)
      chk(regs[k*32 +: 32] === exp_act[k], $sformatf("%s reg%0d", tag, k),
          {32'h0, regs[k*32 +: 32]}, {32'h0, exp_act[k]});
    chk(frac === {exp_act[0][14:3], exp_act[1][15:3]}, {tag, " R8 frac"},
        {39'h0, frac}, {39'h0, exp_act[0][14:3], exp_act[1][15:3]});
    chk(ferr === exp_err, {tag, " R9 frame flag"}, {63'h0, ferr}, {63'h0, exp_err});
  endtask

  task automatic t_reset();
    chk(regs === '0, "R1 regs zero", regs[63:0], 64'h0);
    chk(frac === '0 && commit === 1'b0, "R1 frac/commit zero", {38'h0, commit, frac}, 64'h0);
    chk(ferr === 1'b0 && sdo === 1'b0, "R1 flag/sdo zero", {62'h0, ferr, sdo}, 64'h0);
    // edges without a load change nothing
    for (int i = 0; i < 8; i++) shift_bit(1'b1);
    cnt_m = 0; sh_m = '0;
    for (int i = 0; i < 32; i++) shift_bit(1'b0);
    chk(regs === '0, "R1 no write before load", regs[63:0], 64'h0);
  endtask

  task automatic t_plain();
    write_word(32'hA5C3_1E6B); // reg3
    check_regs("R2 R3 R4 plain reg3");
    write_word(32'h1234_5677); // reg7
    check_regs("R3 reg7 others intact");
    write_word(32'hFFFF_FFFC); // reg4 all ones above address
    check_regs("R2 R4 reg4");
  endtask

  task automatic t_stage();
    int c0;
    write_word(32'hDEAD_BEE9); // reg1
    check_regs("R5 reg1 staged pending");
    write_word(32'h5A5A_A5A2); // reg2
    check_regs("R5 reg2 staged pending");
    c0 = commits_seen;
    write_word(32'h0000_7FF8); // reg0
    check_regs("R6 commit reg0");
    chk(commits_seen == c0 + 1, "R7 one commit pulse", 64'(commits_seen - c0), 64'd1);
    chk(reg0_at_commit === exp_act[0], "R7 reg0 same cycle",
        {32'h0, reg0_at_commit}, {32'h0, exp_act[0]});
    write_word(32'h1111_2221); // reg1
    write_word(32'h0000_4441); // reg1 again, last wins
    check_regs("R5 double pending");
    write_word(32'h0F0F_0000); // reg0
    check_regs("R6 last pending wins");
    c0 = commits_seen;
    write_word(32'hCAFE_0008); // reg0, nothing pending
    check_regs("R6 empty commit");
    chk(commits_seen == c0 + 1, "R7 commit with nothing pending", 64'(commits_seen - c0), 64'd1);
  endtask

  task automatic t_frame();
    send_bits(64'h2_AB12_34C5, 30);
    check_regs("R9 short frame");
    send_bits(64'h1_9876_5436, 33);
    check_regs("R9 long frame");
    write_word(32'h7777_0005);
    check_regs("R9 exact frame clears");
  endtask

  task automatic t_readback();
    logic [36:0] pat;
    pat = 37'h1_5A3C_96E1;
    status = pat;
    sdat = 1'b1;
    txd = 1'b1; cyc(6);
    txd = 1'b0; cyc(6);
    for (int i = 36; i >= 0; i--) begin
      sclk = 1'b1; cyc(5);
      chk(sdo === pat[i], $sformatf("R10 readback bit %0d", i), {63'h0, sdo}, {63'h0, pat[i]});
      cyc(1);
      sclk = 1'b0; cyc(6);
    end
    cyc(4);
    chk(sdo === 1'b0, "R10 sdo idle after readback", {63'h0, sdo}, 64'h0);
    // R11: readback edges did not shift or count
    write_word(32'h3C3C_C3C6);
    check_regs("R11 write after readback");
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin exp_act[k] = '0; exp_pend[k] = '0; end
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_plain();
    t_stage();
    t_frame();
    t_readback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule